// File: doc/BRIEF.md
# Cross-Clock Word Capture by Opposite-Edge Event Sampling

This block carries a stream of data words from a slow source clock (nominally 27 MHz) into a faster destination clock (nominally 50 MHz) with low latency and no FIFO. The source side presents one word per source period. The block registers that word on the falling source edge. On every rising source edge it inverts a divide-by-two marker.

On the destination side, the marker passes through a short synchronizer clocked on the falling destination edge. The data bus is sampled on the rising destination edge into a delay line of matching depth. Two successive falling-edge samples of the marker can differ. When they do, a source rising edge happened between them. The rising-edge data sample taken between those two falling edges then lies within half a destination period of that source edge. That places it well inside the stable window of the source word.

The block emits that sample with a one-cycle valid strobe. Both clocks come from outside. A single active-low asynchronous reset is bridged into each domain separately.

Top module: `xclk_word_capture`

## Requirements
- R1: While the reset input is held low, after at most two destination clock cycles the valid output is 0 and the word output is all zeros, and the source marker is held at 0.
- R2: Every word present on `src_word` at a source rising edge is delivered exactly once, in the order presented and with every bit intact, for any phase between the two clocks.
- R3: Each delivered word raises `dst_valid` for exactly one destination cycle. At source rates up to 28 MHz, `dst_valid` is never high on three consecutive destination cycles.
- R4: After reset the source marker inverts on every rising source edge. Once the source clock halts, the number of delivered words equals the number of source rising edges after lock, minus one.
- R5: In any destination cycle where `dst_valid` is low, `dst_word` keeps its previous value.
- R6: The word presented at source edge n is delivered no later than 60 ns after source edge n+1.
- R7: While the source clock is halted, no valid strobe is produced. When the source clock restarts, delivery resumes with the next word in sequence and none is lost.
- R8: After the reset input is released, the first word delivered is one presented between one source edge before the release and three source edges after it. Strict ordering holds from that word on.
- R9: Delivery stays correct at source rates from about 24 MHz to about 28 MHz, while the destination stays at 50 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock; marker toggles on its rising edge, word is registered on its falling edge |
| clk_dst | input | 1 | Destination clock; marker sampled on falling edge, data and outputs on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, bridged into each clock domain |
| src_word | input | WORD_W | Source data word, one per source period |
| dst_valid | output | 1 | One-cycle strobe marking a newly delivered word |
| dst_word | output | WORD_W | Last delivered word, held between strobes |

## Verification
The two functions that can land on the same instant are the marker detection on the falling destination edge and the change of the source word on the falling source edge. The word must be taken from a rising destination edge that lies between them. The bench provokes this by starting the source clock at a random sub-nanosecond phase and running it at three rates, so that the phase sweeps through every alignment, including edges that nearly coincide. Each strobe is judged against a queue of the words driven, checking order, value and latency. The bench also counts strobes across clock pauses and a mid-run reset.

// File: rtl/xcw_pkg.sv
`timescale 1ns/1ps
package xcw_pkg;

    // default data width of the transported word
    localparam int WORD_W_DEF = 16;
    // falling-edge synchronizer depth for the source marker
    localparam int SYNC_DEPTH_DEF = 2;
    // stages of each reset bridge
    localparam int RST_STAGES_DEF = 2;

    // a source edge happened between two marker samples when they differ
    function automatic logic marker_moved(input logic newer, input logic older);
        return newer ^ older;
    endfunction

endpackage

// File: rtl/xcw_rst_bridge.sv
`timescale 1ns/1ps
module xcw_rst_bridge #(
    parameter int STAGES = xcw_pkg::RST_STAGES_DEF
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst
);

    logic [STAGES-1:0] chain;

    // assert at once, release after STAGES edges of clk
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b0};
        end
    end

    assign rst = chain[STAGES-1];

endmodule

// File: rtl/xcw_src_launch.sv
`timescale 1ns/1ps
module xcw_src_launch #(
    parameter int WORD_W = xcw_pkg::WORD_W_DEF
) (
    input  logic              clk_src,
    input  logic              rst_src,
    input  logic [WORD_W-1:0] src_word,
    output logic              marker,
    output logic [WORD_W-1:0] word_hold
);

    // divide-by-two marker, flips on every rising source edge
    always_ff @(posedge clk_src) begin
        if (rst_src) begin
            marker <= 1'b0;
        end else begin
            marker <= ~marker;
        end
    end

    // word register on the opposite edge: stable for half a period
    // on either side of each marker flip
    always_ff @(negedge clk_src) begin
        if (rst_src) begin
            word_hold <= '0;
        end else begin
            word_hold <= src_word;
        end
    end

endmodule

// File: rtl/xcw_dst_sample.sv
`timescale 1ns/1ps
module xcw_dst_sample #(
    parameter int WORD_W = xcw_pkg::WORD_W_DEF,
    parameter int DEPTH  = xcw_pkg::SYNC_DEPTH_DEF
) (
    input  logic              clk_dst,
    input  logic              rst_dst,
    input  logic              marker_async,
    input  logic [WORD_W-1:0] word_async,
    output logic              dst_valid,
    output logic [WORD_W-1:0] dst_word
);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } cap_t;

    // tsamp[0] is the first synchronizer flop, tsamp[DEPTH] the history flop
    logic [DEPTH:0]             tsamp;
    // pipe[i] holds the rising-edge data sample taken i cycles ago
    logic [DEPTH-1:0][WORD_W-1:0] pipe;
    logic                        hit;
    cap_t                        out_q;

    always_ff @(negedge clk_dst) begin
        if (rst_dst) begin
            tsamp <= '0;
        end else begin
            tsamp <= {tsamp[DEPTH-1:0], marker_async};
        end
    end

    // the edge seen here was sampled by the first stage DEPTH-1 falling
    // edges ago; the rising sample between those two falls sits in pipe[DEPTH-1]
    assign hit = xcw_pkg::marker_moved(tsamp[DEPTH-1], tsamp[DEPTH]);

    always_ff @(posedge clk_dst) begin
        if (rst_dst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= word_async;
            for (int i = 1; i < DEPTH; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    always_ff @(posedge clk_dst) begin
        if (rst_dst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= hit;
            if (hit) begin
                out_q.word <= pipe[DEPTH-1];
            end
        end
    end

    assign dst_valid = out_q.valid;
    assign dst_word  = out_q.word;

endmodule

// File: rtl/xclk_word_capture.sv
`timescale 1ns/1ps
module xclk_word_capture #(
    parameter int WORD_W     = xcw_pkg::WORD_W_DEF,
    parameter int SYNC_DEPTH = xcw_pkg::SYNC_DEPTH_DEF,
    parameter int RST_STAGES = xcw_pkg::RST_STAGES_DEF
) (
    input  logic              clk_src,
    input  logic              clk_dst,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] src_word,
    output logic              dst_valid,
    output logic [WORD_W-1:0] dst_word
);

    logic              rst_src;
    logic              rst_dst;
    logic              src_tgl;
    logic [WORD_W-1:0] src_hold;

    xcw_rst_bridge #(.STAGES(RST_STAGES)) u_rst_src (
        .clk    (clk_src),
        .arst_n (rst_n),
        .rst    (rst_src)
    );

    xcw_rst_bridge #(.STAGES(RST_STAGES)) u_rst_dst (
        .clk    (clk_dst),
        .arst_n (rst_n),
        .rst    (rst_dst)
    );

    xcw_src_launch #(.WORD_W(WORD_W)) u_launch (
        .clk_src   (clk_src),
        .rst_src   (rst_src),
        .src_word  (src_word),
        .marker    (src_tgl),
        .word_hold (src_hold)
    );

    xcw_dst_sample #(.WORD_W(WORD_W), .DEPTH(SYNC_DEPTH)) u_sample (
        .clk_dst      (clk_dst),
        .rst_dst      (rst_dst),
        .marker_async (src_tgl),
        .word_async   (src_hold),
        .dst_valid    (dst_valid),
        .dst_word     (dst_word)
    );

endmodule

// File: rtl/xcw_capture_chk.sv
`timescale 1ns/1ps
module xcw_capture_chk #(
    parameter int WORD_W = xcw_pkg::WORD_W_DEF
) (
    input logic              clk_src,
    input logic              clk_dst,
    input logic              rst_src,
    input logic              rst_dst,
    input logic              src_tgl,
    input logic              dst_valid,
    input logic [WORD_W-1:0] dst_word
);

    // R1
    valid_in_reset_chk: assert property (@(posedge clk_dst)
        rst_dst |=> (!dst_valid && dst_word == '0));

    // R1
    tgl_in_reset_chk: assert property (@(posedge clk_src)
        rst_src |=> !src_tgl);

    // R4
    toggle_flip_chk: assert property (@(posedge clk_src) disable iff (rst_src)
        !rst_src |=> (src_tgl != $past(src_tgl)));

    // R5
    word_hold_chk: assert property (@(posedge clk_dst) disable iff (rst_dst)
        !dst_valid |-> $stable(dst_word));

    // R3
    valid_run_chk: assert property (@(posedge clk_dst) disable iff (rst_dst)
        (dst_valid && $past(dst_valid)) |=> !dst_valid);

endmodule

bind xclk_word_capture xcw_capture_chk #(.WORD_W(WORD_W)) chk_i (
    .clk_src   (clk_src),
    .clk_dst   (clk_dst),
    .rst_src   (rst_src),
    .rst_dst   (rst_dst),
    .src_tgl   (src_tgl),
    .dst_valid (dst_valid),
    .dst_word  (dst_word)
);

// File: tb/xclk_word_capture_tb_top.sv
`timescale 1ns/1ps
module xclk_word_capture_tb_top;

    localparam int W    = 16;
    localparam int NMAX = 4096;

    logic         clk_src = 1'b0;
    logic         clk_dst = 1'b0;
    logic         rst_n   = 1'b1;
    logic [W-1:0] src_word = '0;
    logic         dst_valid;
    logic [W-1:0] dst_word;

    int      checks = 0;
    int      errors = 0;
    real     src_half = 18.5185;
    bit      src_run  = 1'b1;
    bit      done     = 1'b0;

    logic [W-1:0] wr_word [NMAX];
    realtime      edge_t  [NMAX];
    int           n_drv   = 0;
    int           exp_idx = 0;
    bit           locked  = 1'b0;
    int           rel_idx = 0;
    int           recv    = 0;
    int           rst_cyc = 0;
    int           vrun    = 0;
    logic [W-1:0] last_word = '0;

    xclk_word_capture #(.WORD_W(W)) dut_i (
        .clk_src   (clk_src),
        .clk_dst   (clk_dst),
        .rst_n     (rst_n),
        .src_word  (src_word),
        .dst_valid (dst_valid),
        .dst_word  (dst_word)
    );

    function automatic logic [W-1:0] word_of(input int n);
        logic [W-1:0] v;
        v = W'(n) * W'(16'h3B1);
        return v ^ W'(16'hA5C3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // 50 MHz destination clock
    initial forever #10 clk_dst = ~clk_dst;

    // source clock with random start phase; halts low when src_run drops
    initial begin
        int ph;
        ph = $urandom_range(1, 19999);
        #(ph / 1000.0);
        forever begin
            #(src_half);
            if (src_run || clk_src) clk_src = ~clk_src;
        end
    end

    // one new word per source rising edge
    initial forever begin
        @(posedge clk_src);
        if (n_drv < NMAX) begin
            edge_t[n_drv] = $realtime;
            #1;
            src_word = word_of(n_drv);
            wr_word[n_drv] = src_word;
            n_drv++;
        end
    end

    // reference model compared on every destination cycle
    initial forever begin
        @(negedge clk_dst);
        if (!rst_n) begin
            rst_cyc++;
            locked = 1'b0;
            vrun = 0;
            if (rst_cyc >= 3)
                chk(dst_valid == 1'b0 && dst_word == '0, "R1", "outputs in reset",
                    {dst_valid, 15'd0, dst_word}, 32'd0);
        end else begin
            rst_cyc = 0;
            if (dst_valid) begin
                recv++;
                vrun++;
                chk(vrun <= 2, "R3", "valid run length", vrun, 2);
                if (!locked) begin
                    int found;
                    found = -1;
                    for (int j = (rel_idx > 0 ? rel_idx - 1 : 0); j <= rel_idx + 3; j++)
                        if (found < 0 && j < n_drv && wr_word[j] == dst_word) found = j;
                    chk(found >= 0, "R8", "first word after reset", dst_word, wr_word[rel_idx + 1]);
                    exp_idx = (found >= 0) ? found + 1 : rel_idx + 2;
                    locked = 1'b1;
                end else begin
                    realtime lat;
                    chk(dst_word == wr_word[exp_idx], "R2", "delivered word", dst_word, wr_word[exp_idx]);
                    lat = $realtime - edge_t[exp_idx + 1];
                    chk(exp_idx + 1 < n_drv && lat <= 62.0, "R6", "latency ps",
                        $rtoi(lat * 1000.0), 62000);
                    exp_idx++;
                end
            end else begin
                vrun = 0;
                chk(dst_word == last_word, "R5", "word held without valid", dst_word, last_word);
            end
        end
        last_word = dst_word;
    end

    task automatic pause_and_count(input int seg_start, input string rate_tag);
        int r0;
        src_run = 1'b0;
        #200;
        // R4: every edge but the last one delivered its word
        chk(exp_idx == n_drv - 1, "R4", "words delivered at halt", exp_idx, n_drv - 1);
        // R9: segment at this rate delivered a full run of words
        chk(exp_idx - seg_start >= 100, rate_tag, "words in segment", exp_idx - seg_start, 100);
        r0 = recv;
        #2000;
        // R7: halted source clock produces no strobe
        chk(recv == r0, "R7", "strobes while halted", recv, r0);
    endtask

    initial begin
        int seg;
        #1 rst_n = 1'b0;
        repeat (6) @(posedge clk_dst);
        #3.7 rst_n = 1'b1;
        rel_idx = n_drv;

        // segment A: nominal 27 MHz
        repeat (20) @(posedge clk_dst);
        seg = exp_idx;
        repeat (400) @(posedge clk_dst);
        pause_and_count(seg, "R9");

        // segment B: about 24.4 MHz, resume must continue the sequence (R7)
        seg = exp_idx;
        src_half = 20.5;
        src_run = 1'b1;
        repeat (400) @(posedge clk_dst);
        chk(exp_idx > seg + 100, "R7", "delivery resumed after halt", exp_idx, seg + 100);
        pause_and_count(seg, "R9");

        // segment C: about 27.8 MHz with a reset in the middle (R1, R8)
        src_half = 18.0;
        src_run = 1'b1;
        repeat (100) @(posedge clk_dst);
        #5.3 rst_n = 1'b0;
        repeat (8) @(posedge clk_dst);
        #2.1 rst_n = 1'b1;
        rel_idx = n_drv;
        repeat (20) @(posedge clk_dst);
        seg = exp_idx;
        repeat (400) @(posedge clk_dst);
        pause_and_count(seg, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule